// File: doc/BRIEF.md
# Memory Access Protection Checker

This block decides, one request at a time, whether a memory access may proceed. Each request carries a byte address, a byte count, an access kind (data read, data write, instruction fetch or a read issued by a page-table walk) and the privilege level of the requester. The block holds a small table of protection entries. Each entry stores one address word, an address-matching mode, three permission bits and a lock bit. The verdict is registered and comes out one cycle after the request, either as a grant or as a fault code that names the class of access fault.

Software or a control unit fills the table through a simple write port that updates one whole entry per cycle. The checker is meant to sit beside a load/store or fetch path, and beside the walker of an address translation unit, in the cycle that follows address generation. The effective privilege of data accesses can be lowered from machine level to a saved previous level. A locked entry holds its contents until reset and binds machine-level accesses as well.

Top module: `pmp_checker`

## Requirements
- R1: The block returns a response one cycle after each cycle in which `req_valid` is high, with `rsp_valid` high. When `rsp_valid` is low, `rsp_allow` is low and `rsp_fault` is 0.
- R2: Entry mode 2'b01 (range mode) covers the bytes from the address word of the entry below it (0 for entry 0) up to its own address word minus one, both ends inclusive. Modes 2'b00 and 2'b10 are off. An entry that is off never matches, even when the access falls inside the numbers it holds.
- R3: Entry mode 2'b11 (aligned power-of-two mode) uses an address word that ends in k one bits. It covers 2^(k+1) bytes, starting at that word with its low k+1 bits cleared.
- R4: An access covers the bytes from `req_addr` to `req_addr + req_size - 1` (size 1 to 15). If the deciding entry covers only part of that span, the access is denied.
- R5: An entry matches if it overlaps any byte of the access. When several entries match, the one with the lowest index decides.
- R6: Permission bits: bit 0 allows reads, bit 1 allows writes and bit 2 allows fetches. Kind 2'b00 (read) and kind 2'b11 (walk read) need bit 0, kind 2'b01 (write) needs bit 1 and kind 2'b10 (fetch) needs bit 2.
- R7: Privilege codes are 0 for user, 1 for supervisor and 3 for machine. For read, write and walk-read kinds, when `req_priv` is 3 and `req_mprv` is high, the level checked is `req_mpp`. Fetches always use `req_priv`.
- R8: At machine level, a deciding entry that is unlocked grants the access. A locked deciding entry applies its permission bits at machine level too.
- R9: When no entry matches, machine level is granted. Lower levels are denied if any entry is on, and granted if every entry is off.
- R10: A write to a locked entry changes nothing, including its mode, permissions, address word and lock, until reset. Writes to unlocked entries take effect.
- R11: `rsp_fault` is 0 on a grant. On a denial it is 1 for a read or a walk read (an access fault, never a translation fault), 2 for a write and 3 for a fetch.
- R12: A request checked in the same cycle as an entry write is judged against the entry contents from before that write.
- R13: Reset clears every entry to off, unlocked, with address word 0, and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W | Index of the entry written |
| cfg_addr | input | ADDR_W | Address word for the entry |
| cfg_mode | input | 2 | Matching mode for the entry |
| cfg_perm | input | 3 | Permission bits {fetch, write, read} |
| cfg_lock | input | 1 | Lock bit for the entry |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | First byte address of the access |
| req_size | input | SIZE_W | Number of bytes accessed |
| req_kind | input | 2 | Access kind |
| req_priv | input | 2 | Current privilege level |
| req_mprv | input | 1 | Data accesses at machine level use the saved level |
| req_mpp | input | 2 | Saved previous privilege level |
| rsp_valid | output | 1 | Verdict present |
| rsp_allow | output | 1 | Access granted |
| rsp_fault | output | 2 | Fault class when denied |

## Verification
An entry write and an access check can land in the same cycle, and the same entry can be both the one being written and the one that decides the access. The bench provokes this by rewriting the permissions of a range entry in the very cycle a user-level read targets that range. It expects the grant computed from the old permissions. The next read is expected to be denied under the new permissions, and a fetch to be granted, so both the old and the new contents are seen through the verdict.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

   typedef enum logic [1:0] {
      AM_OFF   = 2'b00,
      AM_RANGE = 2'b01,
      AM_RSVD  = 2'b10,
      AM_POW2  = 2'b11
   } amode_e;

   typedef enum logic [1:0] {
      AK_READ  = 2'b00,
      AK_WRITE = 2'b01,
      AK_FETCH = 2'b10,
      AK_WALK  = 2'b11
   } akind_e;

   localparam logic [1:0] LVL_MACHINE = 2'b11;

   localparam logic [1:0] FLT_NONE  = 2'd0;
   localparam logic [1:0] FLT_LOAD  = 2'd1;
   localparam logic [1:0] FLT_STORE = 2'd2;
   localparam logic [1:0] FLT_FETCH = 2'd3;

   localparam int PERM_BIT_R = 0;
   localparam int PERM_BIT_W = 1;
   localparam int PERM_BIT_X = 2;

   function automatic logic mode_active(input logic [1:0] m);
      return (m == AM_RANGE) || (m == AM_POW2);
   endfunction

endpackage

// File: rtl/pmp_entry_bank.sv
module pmp_entry_bank
   import pmp_pkg::*;
#(
   parameter int N_ENTRIES = 8,
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 3
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [IDX_W-1:0]                     wr_idx,
   input  logic [ADDR_W-1:0]                    wr_addr,
   input  logic [1:0]                           wr_mode,
   input  logic [2:0]                           wr_perm,
   input  logic                                 wr_lock,
   output logic [N_ENTRIES-1:0][ADDR_W-1:0]     ent_addr,
   output logic [N_ENTRIES-1:0][1:0]            ent_mode,
   output logic [N_ENTRIES-1:0][2:0]            ent_perm,
   output logic [N_ENTRIES-1:0]                 ent_lock
);

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
      logic [ADDR_W-1:0] addr_q;
      logic [1:0]        mode_q;
      logic [2:0]        perm_q;
      logic              lock_q;
      logic              take;

      // a locked slot refuses every update until reset
      assign take = wr_en && (wr_idx == IDX_W'(i)) && !lock_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q <= '0;
            mode_q <= AM_OFF;
            perm_q <= '0;
            lock_q <= 1'b0;
         end else if (take) begin
            addr_q <= wr_addr;
            mode_q <= wr_mode;
            perm_q <= wr_perm;
            lock_q <= wr_lock;
         end
      end

      assign ent_addr[i] = addr_q;
      assign ent_mode[i] = mode_q;
      assign ent_perm[i] = perm_q;
      assign ent_lock[i] = lock_q;
   end

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
   import pmp_pkg::*;
#(
   parameter int N_ENTRIES = 8,
   parameter int ADDR_W    = 32
) (
   input  logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_addr,
   input  logic [N_ENTRIES-1:0][1:0]        ent_mode,
   input  logic [ADDR_W:0]                  acc_first,
   input  logic [ADDR_W:0]                  acc_last,
   output logic [N_ENTRIES-1:0]             hit_any,
   output logic [N_ENTRIES-1:0]             hit_full
);

   localparam int EXT_W = ADDR_W + 1;

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_rgn
      logic [ADDR_W-1:0] base;
      logic [ADDR_W-1:0] span_mask;
      logic [EXT_W-1:0]  lo;
      logic [EXT_W-1:0]  hi;
      logic              live;

      if (i == 0) begin : g_base_zero
         assign base = '0;
      end else begin : g_base_prev
         assign base = ent_addr[i-1];
      end

      // trailing ones plus the first zero above them
      assign span_mask = ent_addr[i] ^ (ent_addr[i] + ADDR_W'(1));

      always_comb begin
         lo   = '0;
         hi   = '0;
         live = 1'b0;
         case (ent_mode[i])
            AM_RANGE: begin
               lo   = {1'b0, base};
               hi   = {1'b0, ent_addr[i]} - EXT_W'(1);
               live = ent_addr[i] > base;
            end
            AM_POW2: begin
               lo   = {1'b0, ent_addr[i] & ~span_mask};
               hi   = {1'b0, ent_addr[i] | span_mask};
               live = 1'b1;
            end
            default: begin
               live = 1'b0;
            end
         endcase
      end

      // hi is the last byte inside the region: both ends compare inclusive
      assign hit_any[i]  = live && (acc_first <= hi) && (acc_last >= lo);
      assign hit_full[i] = live && (acc_first >= lo) && (acc_last <= hi);
   end

endmodule

// File: rtl/pmp_first_hit.sv
module pmp_first_hit #(
   parameter int N_ENTRIES = 8,
   parameter int IDX_W     = 3
) (
   input  logic [N_ENTRIES-1:0] hit,
   output logic                 found,
   output logic [IDX_W-1:0]     idx
);

   always_comb begin
      found = |hit;
      idx   = '0;
      for (int k = N_ENTRIES - 1; k >= 0; k--) begin
         if (hit[k]) idx = IDX_W'(k);
      end
   end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
   import pmp_pkg::*;
#(
   parameter int N_ENTRIES = 8,
   parameter int ADDR_W    = 32,
   parameter int SIZE_W    = 4,
   localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [1:0]        cfg_mode,
   input  logic [2:0]        cfg_perm,
   input  logic              cfg_lock,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [1:0]        req_kind,
   input  logic [1:0]        req_priv,
   input  logic              req_mprv,
   input  logic [1:0]        req_mpp,
   output logic              rsp_valid,
   output logic              rsp_allow,
   output logic [1:0]        rsp_fault
);

   localparam int EXT_W = ADDR_W + 1;

   initial begin : chk_params
      if (N_ENTRIES < 1 || N_ENTRIES > 64)
         $fatal(1, "pmp_checker: N_ENTRIES out of range");
      if (ADDR_W < 8 || ADDR_W > 64)
         $fatal(1, "pmp_checker: ADDR_W out of range");
      if (SIZE_W < 1 || SIZE_W >= ADDR_W)
         $fatal(1, "pmp_checker: SIZE_W out of range");
   end

   logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_addr;
   logic [N_ENTRIES-1:0][1:0]        ent_mode;
   logic [N_ENTRIES-1:0][2:0]        ent_perm;
   logic [N_ENTRIES-1:0]             ent_lock;

   pmp_entry_bank #(
      .N_ENTRIES (N_ENTRIES),
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_idx   (cfg_idx),
      .wr_addr  (cfg_addr),
      .wr_mode  (cfg_mode),
      .wr_perm  (cfg_perm),
      .wr_lock  (cfg_lock),
      .ent_addr (ent_addr),
      .ent_mode (ent_mode),
      .ent_perm (ent_perm),
      .ent_lock (ent_lock)
   );

   logic [EXT_W-1:0] acc_first;
   logic [EXT_W-1:0] acc_last;

   assign acc_first = {1'b0, req_addr};
   assign acc_last  = acc_first + EXT_W'(req_size) - EXT_W'(1);

   logic [N_ENTRIES-1:0] hit_any;
   logic [N_ENTRIES-1:0] hit_full;

   pmp_region_match #(
      .N_ENTRIES (N_ENTRIES),
      .ADDR_W    (ADDR_W)
   ) u_match (
      .ent_addr  (ent_addr),
      .ent_mode  (ent_mode),
      .acc_first (acc_first),
      .acc_last  (acc_last),
      .hit_any   (hit_any),
      .hit_full  (hit_full)
   );

   logic             hit_found;
   logic [IDX_W-1:0] hit_idx;

   pmp_first_hit #(
      .N_ENTRIES (N_ENTRIES),
      .IDX_W     (IDX_W)
   ) u_prio (
      .hit   (hit_any),
      .found (hit_found),
      .idx   (hit_idx)
   );

   // effective level: data accesses may be lowered from machine level
   logic [1:0] eff_lvl;
   logic       at_machine;

   always_comb begin
      eff_lvl = req_priv;
      if (req_kind != AK_FETCH && req_mprv && req_priv == LVL_MACHINE)
         eff_lvl = req_mpp;
   end

   assign at_machine = (eff_lvl == LVL_MACHINE);

   logic any_active;

   always_comb begin
      any_active = 1'b0;
      for (int k = 0; k < N_ENTRIES; k++) begin
         if (mode_active(ent_mode[k])) any_active = 1'b1;
      end
   end

   logic [2:0] sel_perm;
   logic       sel_lock;
   logic       sel_full;
   logic       perm_ok;
   logic       grant;
   logic [1:0] deny_code;

   assign sel_perm = ent_perm[hit_idx];
   assign sel_lock = ent_lock[hit_idx];
   assign sel_full = hit_full[hit_idx];

   always_comb begin
      case (req_kind)
         AK_WRITE: perm_ok = sel_perm[PERM_BIT_W];
         AK_FETCH: perm_ok = sel_perm[PERM_BIT_X];
         default:  perm_ok = sel_perm[PERM_BIT_R];
      endcase
   end

   always_comb begin
      if (hit_found) begin
         if (!sel_full)                   grant = 1'b0;
         else if (at_machine && !sel_lock) grant = 1'b1;
         else                             grant = perm_ok;
      end else begin
         grant = at_machine || !any_active;
      end
   end

   always_comb begin
      case (req_kind)
         AK_WRITE: deny_code = FLT_STORE;
         AK_FETCH: deny_code = FLT_FETCH;
         default:  deny_code = FLT_LOAD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_allow <= 1'b0;
         rsp_fault <= FLT_NONE;
      end else begin
         rsp_valid <= req_valid;
         rsp_allow <= req_valid && grant;
         rsp_fault <= (req_valid && !grant) ? deny_code : FLT_NONE;
      end
   end

endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva #(
   parameter int N_ENTRIES = 8,
   parameter int ADDR_W    = 32
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             req_valid,
   input logic [1:0]                       req_kind,
   input logic                             rsp_valid,
   input logic                             rsp_allow,
   input logic [1:0]                       rsp_fault,
   input logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_addr,
   input logic [N_ENTRIES-1:0][1:0]        ent_mode,
   input logic [N_ENTRIES-1:0][2:0]        ent_perm,
   input logic [N_ENTRIES-1:0]             ent_lock
);

   a_r1_answer_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r1_no_answer_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r1_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_allow && rsp_fault == 2'd0));

   a_r11_code_matches_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_allow == (rsp_fault == 2'd0)));

   a_r11_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'b10) |=> (rsp_allow || rsp_fault == 2'd3));

   a_r11_write_code: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'b01) |=> (rsp_allow || rsp_fault == 2'd2));

   a_r11_read_code: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_kind == 2'b00 || req_kind == 2'b11)) |=> (rsp_allow || rsp_fault == 2'd1));

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_lock
      a_r10_locked_entry_frozen: assert property (@(posedge clk) disable iff (!rst_n)
         ent_lock[i] |=> (ent_lock[i] && $stable(ent_addr[i]) && $stable(ent_mode[i])
                          && $stable(ent_perm[i])));
   end

endmodule

bind pmp_checker pmp_checker_sva #(
   .N_ENTRIES (N_ENTRIES),
   .ADDR_W    (ADDR_W)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_kind  (req_kind),
   .rsp_valid (rsp_valid),
   .rsp_allow (rsp_allow),
   .rsp_fault (rsp_fault),
   .ent_addr  (ent_addr),
   .ent_mode  (ent_mode),
   .ent_perm  (ent_perm),
   .ent_lock  (ent_lock)
);

// File: tb/tb_pmp_checker.sv
module tb_pmp_checker;

   localparam int N_ENTRIES = 8;
   localparam int ADDR_W    = 32;
   localparam int SIZE_W    = 4;
   localparam int IDX_W     = 3;

   localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_FX = 2'b10, K_PT = 2'b11;
   localparam logic [1:0] P_U = 2'd0, P_S = 2'd1, P_M = 2'd3;
   localparam logic [1:0] M_OFF = 2'b00, M_RNG = 2'b01, M_RSV = 2'b10, M_P2 = 2'b11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [IDX_W-1:0]  cfg_idx = '0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [1:0]        cfg_mode = '0;
   logic [2:0]        cfg_perm = '0;
   logic              cfg_lock = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [SIZE_W-1:0] req_size = '0;
   logic [1:0]        req_kind = '0;
   logic [1:0]        req_priv = '0;
   logic              req_mprv = 1'b0;
   logic [1:0]        req_mpp = '0;
   logic              rsp_valid;
   logic              rsp_allow;
   logic [1:0]        rsp_fault;

   always #4 clk = ~clk;

   pmp_checker #(
      .N_ENTRIES (N_ENTRIES),
      .ADDR_W    (ADDR_W),
      .SIZE_W    (SIZE_W)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_addr  (cfg_addr),
      .cfg_mode  (cfg_mode),
      .cfg_perm  (cfg_perm),
      .cfg_lock  (cfg_lock),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .req_kind  (req_kind),
      .req_priv  (req_priv),
      .req_mprv  (req_mprv),
      .req_mpp   (req_mpp),
      .rsp_valid (rsp_valid),
      .rsp_allow (rsp_allow),
      .rsp_fault (rsp_fault)
   );

   typedef struct {
      logic       allow;
      logic [1:0] fault;
      string      tag;
   } exp_t;

   exp_t sb_q[$];
   exp_t got;
   int   n_checks = 0;
   int   n_errs   = 0;

   // monitor: pops one expected verdict per response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         n_checks++;
         if (sb_q.size() == 0) begin
            n_errs++;
            $display("FAIL R1: response with nothing pending (allow=%0b fault=%0d, expected none)",
                     rsp_allow, rsp_fault);
         end else begin
            got = sb_q.pop_front();
            if (rsp_allow !== got.allow || rsp_fault !== got.fault) begin
               n_errs++;
               $display("FAIL %s: allow=%0b fault=%0d, expected allow=%0b fault=%0d",
                        got.tag, rsp_allow, rsp_fault, got.allow, got.fault);
            end
         end
      end
   end

   task automatic clear_inputs();
      cfg_we    = 1'b0;
      req_valid = 1'b0;
      req_mprv  = 1'b0;
   endtask

   task automatic put_cfg(input int idx, input logic [ADDR_W-1:0] a, input logic [1:0] m,
                          input logic [2:0] p, input logic lk);
      cfg_we   = 1'b1;
      cfg_idx  = IDX_W'(idx);
      cfg_addr = a;
      cfg_mode = m;
      cfg_perm = p;
      cfg_lock = lk;
   endtask

   task automatic put_req(input logic [ADDR_W-1:0] a, input int sz, input logic [1:0] k,
                          input logic [1:0] pv, input logic mp, input logic [1:0] pp,
                          input logic ea, input logic [1:0] ef, input string tag);
      exp_t e;
      req_valid = 1'b1;
      req_addr  = a;
      req_size  = SIZE_W'(sz);
      req_kind  = k;
      req_priv  = pv;
      req_mprv  = mp;
      req_mpp   = pp;
      e.allow = ea;
      e.fault = ef;
      e.tag   = tag;
      sb_q.push_back(e);
   endtask

   task automatic wr_entry(input int idx, input logic [ADDR_W-1:0] a, input logic [1:0] m,
                           input logic [2:0] p, input logic lk);
      @(negedge clk);
      clear_inputs();
      put_cfg(idx, a, m, p, lk);
   endtask

   task automatic access(input logic [ADDR_W-1:0] a, input int sz, input logic [1:0] k,
                         input logic [1:0] pv, input logic mp, input logic [1:0] pp,
                         input logic ea, input logic [1:0] ef, input string tag);
      @(negedge clk);
      clear_inputs();
      put_req(a, sz, k, pv, mp, pp, ea, ef, tag);
   endtask

   task automatic idle();
      @(negedge clk);
      clear_inputs();
   endtask

   task automatic direct_check(input logic cond, input string msg);
      n_checks++;
      if (!cond) begin
         n_errs++;
         $display("FAIL %s", msg);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      direct_check(rsp_valid === 1'b0 && rsp_allow === 1'b0 && rsp_fault === 2'd0,
                   $sformatf("R13: in reset valid=%0b allow=%0b fault=%0d, expected 0 0 0",
                             rsp_valid, rsp_allow, rsp_fault));
      rst_n = 1'b1;
      idle();
      idle();
      direct_check(rsp_valid === 1'b0,
                   $sformatf("R1: idle valid=%0b, expected 0", rsp_valid));

      // R13 / R9: every entry off after reset, so user level is granted
      access(32'h1000, 4, K_RD, P_U, 1'b0, P_U, 1'b1, 2'd0, "R9 all entries off");

      wr_entry(0, 32'h207F, M_P2,  3'b001, 1'b0);  // 0x2000..0x20FF read only
      wr_entry(1, 32'h3000, M_OFF, 3'b111, 1'b0);  // off, base for entry 2
      wr_entry(2, 32'h3100, M_RNG, 3'b011, 1'b0);  // 0x3000..0x30FF read/write
      wr_entry(3, 32'h27FF, M_P2,  3'b111, 1'b0);  // 0x2000..0x2FFF all
      wr_entry(4, 32'h407F, M_P2,  3'b100, 1'b1);  // 0x4000..0x40FF fetch, locked
      wr_entry(5, 32'h507F, M_RSV, 3'b111, 1'b0);  // reserved mode is off

      access(32'h2010, 4, K_RD, P_U, 1'b0, P_U, 1'b1, 2'd0, "R3 aligned region read");
      access(32'h2010, 4, K_WR, P_U, 1'b0, P_U, 1'b0, 2'd2, "R5 lowest entry decides");
      access(32'h2200, 4, K_WR, P_U, 1'b0, P_U, 1'b1, 2'd0, "R5 later entry past first");
      access(32'h20FC, 4, K_RD, P_U, 1'b0, P_U, 1'b1, 2'd0, "R4 last byte inclusive");
      access(32'h20FD, 4, K_RD, P_U, 1'b0, P_U, 1'b0, 2'd1, "R4 straddle region end");
      access(32'h1FFF, 2, K_RD, P_U, 1'b0, P_U, 1'b0, 2'd1, "R4 straddle region start");
      access(32'h2FFC, 4, K_WR, P_U, 1'b0, P_U, 1'b1, 2'd0, "R3 aligned region top");
      access(32'h2FFD, 4, K_WR, P_U, 1'b0, P_U, 1'b0, 2'd2, "R4 partial into next region");
      access(32'h3000, 8, K_RD, P_U, 1'b0, P_U, 1'b1, 2'd0, "R2 range start inclusive");
      access(32'h30F8, 8, K_WR, P_U, 1'b0, P_U, 1'b1, 2'd0, "R2 range end inclusive");
      access(32'h3100, 1, K_RD, P_U, 1'b0, P_U, 1'b0, 2'd1, "R2 range top exclusive");
      access(32'h3000, 1, K_FX, P_U, 1'b0, P_U, 1'b0, 2'd3, "R2 off entry never matches");
      access(32'h5000, 4, K_RD, P_U, 1'b0, P_U, 1'b0, 2'd1, "R2 reserved mode is off");
      access(32'h3010, 4, K_FX, P_M, 1'b0, P_U, 1'b1, 2'd0, "R8 machine unlocked entry");
      access(32'h5000, 4, K_RD, P_M, 1'b0, P_U, 1'b1, 2'd0, "R9 machine no match");
      access(32'h4000, 4, K_RD, P_M, 1'b0, P_U, 1'b0, 2'd1, "R8 locked entry binds machine");
      access(32'h4000, 4, K_FX, P_M, 1'b0, P_U, 1'b1, 2'd0, "R6 locked fetch allowed");
      access(32'h2010, 4, K_WR, P_M, 1'b0, P_U, 1'b1, 2'd0, "R8 machine write unlocked");
      access(32'h2010, 4, K_WR, P_M, 1'b1, P_U, 1'b0, 2'd2, "R7 lowered data level");
      access(32'h2010, 4, K_FX, P_M, 1'b1, P_U, 1'b1, 2'd0, "R7 fetch keeps machine");
      access(32'h4010, 8, K_PT, P_S, 1'b0, P_U, 1'b0, 2'd1, "R11 walk read access fault");
      access(32'h2010, 8, K_PT, P_S, 1'b0, P_U, 1'b1, 2'd0, "R6 walk read granted");

      // R10: rewrite of the locked slot must not take effect
      wr_entry(4, 32'h0, M_OFF, 3'b111, 1'b0);
      access(32'h4000, 4, K_RD, P_M, 1'b0, P_U, 1'b0, 2'd1, "R10 locked entry unchanged");
      access(32'h4000, 4, K_FX, P_S, 1'b0, P_U, 1'b1, 2'd0, "R10 locked perms kept");

      // R12: write and check in the same cycle use the old contents
      @(negedge clk);
      clear_inputs();
      put_cfg(2, 32'h3100, M_RNG, 3'b100, 1'b0);
      put_req(32'h3010, 4, K_RD, P_U, 1'b0, P_U, 1'b1, 2'd0, "R12 same cycle sees old");
      access(32'h3010, 4, K_RD, P_U, 1'b0, P_U, 1'b0, 2'd1, "R12 next cycle sees new");
      access(32'h3010, 4, K_FX, P_U, 1'b0, P_U, 1'b1, 2'd0, "R10 unlocked rewrite works");

      idle();
      idle();
      idle();
      direct_check(sb_q.size() == 0,
                   $sformatf("R1: %0d responses missing, expected 0", sb_q.size()));

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

endmodule